// File: doc/BRIEF.md
# Parallel NOR Flash Operation Sequencer

This block sits on the host side of a 16-bit parallel NOR flash with 64K words. It drives the flash's address bus, its outbound data bus and its three active-low strobes: chip enable, write enable and output enable. The host hands it one request at a time: read a word, program a word, erase a 2K-word sector, or erase the whole array. The block turns each request into the timed bus cycles that the flash needs. A read takes a single read cycle. A program or an erase takes an unlock-and-command write sequence, followed by status reads until the flash reports that it has finished.

Two ways of detecting completion can be chosen per request. In toggle mode the block watches status bit 6, which flips on every read while the flash is busy. In inverted-data mode it watches bit 7, which reads as the complement of the final value until the operation ends. A clock-cycle timeout runs for each kind of operation. If polling runs past it, the block raises an error pulse and returns to idle. Strobe setup, pulse, hold and recovery times are parameters counted in clock cycles.

Top module: `nor_wr_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, all three strobes are high, the data bus is not driven (dq_oe = 0), req_ready is 1, and done and timeout_err are 0.
- R2: A read request (req_op = 0) makes exactly one bus cycle, with output enable low and write enable high, and no write cycle. The word present on flash_dq_in at the end of the output-enable pulse appears on rd_data, with a done pulse.
- R3: A program request (req_op = 1) issues four write cycles in this order: 0x00AA to 0x5555, 0x0055 to 0x2AAA, 0x00A0 to 0x5555, then req_data to req_addr.
- R4: A sector-erase request (req_op = 2) issues six write cycles in this order: 0x00AA to 0x5555, 0x0055 to 0x2AAA, 0x0080 to 0x5555, 0x00AA to 0x5555, 0x0055 to 0x2AAA, then 0x0030 to the sector address. The sector address is req_addr[15:11] with bits 10:0 at zero.
- R5: A chip-erase request (req_op = 3) issues the same first five write cycles as R4 and ends with 0x0010 to 0x5555.
- R6: With poll_data = 0, after the last command write the block repeats status reads. It pulses done only when two consecutive reads return the same value in bit 6, which is never before the flash has stopped toggling that bit.
- R7: With poll_data = 1, the block repeats status reads and pulses done only when bit 7 equals req_data[7] for a program, or equals 1 for an erase.
- R8: If completion has not been seen and at least TO_PROG, TO_SECT or TO_CHIP clock cycles (matching the operation) have passed since polling began, the block pulses timeout_err instead of done after the current status read. It then returns req_ready high and accepts and completes the next request.
- R9: On every bus cycle the address is stable for as long as chip enable is low. Chip enable goes low at least one cycle before either of the other strobes. Write enable and output enable are never low together, and write enable is low only while chip enable is low. Each write-enable or output-enable pulse lasts exactly T_PULSE cycles. Write data is driven and unchanged across the rising edge of write enable. Chip enable stays high for at least T_RECOV cycles between bus cycles.
- R10: A request presented while req_ready is 0 is ignored: it causes no bus cycle, either during the running operation or after it.
- R11: done and timeout_err are single-cycle pulses, never high together, and each comes with req_ready high. req_ready goes low in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | 16 | Word address (sector taken from bits 15:11) |
| req_data | input | 16 | Word to program |
| poll_data | input | 1 | 0 toggle-bit polling, 1 inverted-data polling |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle pulse when an operation completes |
| timeout_err | output | 1 | One-cycle pulse when polling times out |
| rd_data | output | 16 | Word returned by the last read request |
| flash_addr | output | 16 | Flash address bus |
| flash_dq_out | output | 16 | Data driven toward the flash |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_out |
| flash_dq_in | input | 16 | Data returned by the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
Each operation kind runs against a behavioural flash model that decodes the command writes, holds the array, and returns status words while busy. Comparing the captured write list with the expected list separates the four sequences and the sector-address masking. Programs run with data whose bit 7 is 0 and with data whose bit 7 is 1, in both polling modes; this shows whether the block compares the right bit against the right target and whether it stops before the flash has finished. Read-backs after a sector erase tell a word inside the erased sector apart from a word outside it. A model that never finishes, and requests held high while the block is busy, exercise the timeout and ignore paths, while a per-clock strobe monitor checks the bus timing on every cycle.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam int AW        = 16;
  localparam int DW        = 16;
  localparam int SECT_BITS = 5;
  localparam int SECT_OFS  = AW - SECT_BITS;

  localparam logic [AW-1:0] UNLK_A1 = 16'h5555;
  localparam logic [AW-1:0] UNLK_A2 = 16'h2AAA;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_RECOV
  } ph_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CMD, ST_RDOP, ST_POLL
  } ctl_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          last;
  } step_t;

  // Command write for position idx of the sequence belonging to op.
  function automatic step_t cmd_step(op_e op, logic [2:0] idx,
                                     logic [AW-1:0] a, logic [DW-1:0] d);
    step_t s;
    s.addr = UNLK_A1;
    s.data = DW'(8'hAA);
    s.last = 1'b0;
    case (idx)
      3'd0: begin s.addr = UNLK_A1; s.data = DW'(8'hAA); end
      3'd1: begin s.addr = UNLK_A2; s.data = DW'(8'h55); end
      3'd2: begin
        s.addr = UNLK_A1;
        s.data = (op == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
      end
      3'd3: begin
        if (op == OP_PROG) begin
          s.addr = a; s.data = d; s.last = 1'b1;
        end else begin
          s.addr = UNLK_A1; s.data = DW'(8'hAA);
        end
      end
      3'd4: begin s.addr = UNLK_A2; s.data = DW'(8'h55); end
      default: begin
        s.last = 1'b1;
        if (op == OP_SECT) begin
          s.addr = {a[AW-1:SECT_OFS], {SECT_OFS{1'b0}}};
          s.data = DW'(8'h30);
        end else begin
          s.addr = UNLK_A1;
          s.data = DW'(8'h10);
        end
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 1,
  parameter int T_RECOV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_in,
  output logic          cyc_done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n
);
  localparam int M1   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int M2   = (T_HOLD > T_RECOV) ? T_HOLD : T_RECOV;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      cyc_done <= 1'b0;
      rdata    <= '0;
      addr_o   <= '0;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
    end else begin
      cyc_done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_SETUP;
          cnt    <= CW'(T_SETUP - 1);
          ce_n   <= 1'b0;
          addr_o <= addr;
          dq_o   <= wdata;
          dq_oe  <= wr;
          wr_q   <= wr;
        end
        PH_SETUP: if (cnt == '0) begin
          ph   <= PH_PULSE;
          cnt  <= CW'(T_PULSE - 1);
          we_n <= ~wr_q;
          oe_n <= wr_q;
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin
          ph   <= PH_HOLD;
          cnt  <= CW'(T_HOLD - 1);
          we_n <= 1'b1;
          oe_n <= 1'b1;
          if (!wr_q) rdata <= dq_in;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          ph    <= PH_RECOV;
          cnt   <= CW'(T_RECOV - 1);
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
        end else cnt <= cnt - 1'b1;
        PH_RECOV: if (cnt == '0) begin
          ph       <= PH_IDLE;
          cyc_done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_timer.sv
module nor_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nor_wr_ctrl.sv
module nor_wr_ctrl
  import nor_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 1,
  parameter int T_RECOV = 2,
  parameter int TMR_W   = 32,
  parameter int TO_PROG = 40_000,
  parameter int TO_SECT = 20_000_000,
  parameter int TO_CHIP = 100_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          poll_data,
  output logic          req_ready,
  output logic          done,
  output logic          timeout_err,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] flash_addr,
  output logic [DW-1:0] flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [DW-1:0] flash_dq_in,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n
);
  ctl_e          st;
  op_e           op_q;
  logic [AW-1:0] addr_q, cyc_addr;
  logic [DW-1:0] data_q, cyc_data, bc_rdata;
  logic          mode_q, cyc_wr, start_q, inflight;
  logic [2:0]    step_q;
  logic          have_prev, prev6;
  logic          bc_done, expired, poll_ok, exp7;
  logic [TMR_W-1:0] limit;
  step_t         cur;

  always_comb cur = cmd_step(op_q, step_q, addr_q, data_q);

  assign exp7    = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign poll_ok = mode_q ? (bc_rdata[7] == exp7)
                          : (have_prev && (bc_rdata[6] == prev6));

  always_comb begin
    case (op_q)
      OP_SECT: limit = TMR_W'(TO_SECT);
      OP_CHIP: limit = TMR_W'(TO_CHIP);
      default: limit = TMR_W'(TO_PROG);
    endcase
  end

  nor_bus_cycle #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_RECOV(T_RECOV)
  ) bus_i (
    .clk(clk), .rst(rst), .start(start_q), .wr(cyc_wr),
    .addr(cyc_addr), .wdata(cyc_data), .dq_in(flash_dq_in),
    .cyc_done(bc_done), .rdata(bc_rdata),
    .addr_o(flash_addr), .dq_o(flash_dq_out), .dq_oe(flash_dq_oe),
    .ce_n(flash_ce_n), .we_n(flash_we_n), .oe_n(flash_oe_n)
  );

  nor_timer #(.W(TMR_W)) tmr_i (
    .clk(clk), .rst(rst), .clr(st != ST_POLL), .limit(limit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      data_q      <= '0;
      mode_q      <= 1'b0;
      step_q      <= '0;
      cyc_addr    <= '0;
      cyc_data    <= '0;
      cyc_wr      <= 1'b0;
      start_q     <= 1'b0;
      inflight    <= 1'b0;
      have_prev   <= 1'b0;
      prev6       <= 1'b0;
      req_ready   <= 1'b1;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rd_data     <= '0;
    end else begin
      start_q     <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q      <= op_e'(req_op);
          addr_q    <= req_addr;
          data_q    <= req_data;
          mode_q    <= poll_data;
          step_q    <= '0;
          inflight  <= 1'b0;
          req_ready <= 1'b0;
          st        <= (op_e'(req_op) == OP_READ) ? ST_RDOP : ST_CMD;
        end
        ST_CMD: begin
          if (!inflight) begin
            start_q  <= 1'b1;
            inflight <= 1'b1;
            cyc_addr <= cur.addr;
            cyc_data <= cur.data;
            cyc_wr   <= 1'b1;
          end else if (bc_done) begin
            inflight <= 1'b0;
            if (cur.last) begin
              st        <= ST_POLL;
              have_prev <= 1'b0;
            end else begin
              step_q <= step_q + 3'd1;
            end
          end
        end
        default: begin
          if (!inflight) begin
            start_q  <= 1'b1;
            inflight <= 1'b1;
            cyc_addr <= addr_q;
            cyc_wr   <= 1'b0;
          end else if (bc_done) begin
            inflight <= 1'b0;
            if (st == ST_RDOP) begin
              rd_data   <= bc_rdata;
              done      <= 1'b1;
              req_ready <= 1'b1;
              st        <= ST_IDLE;
            end else if (poll_ok) begin
              done      <= 1'b1;
              req_ready <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              have_prev <= 1'b1;
              prev6     <= bc_rdata[6];
              if (expired) begin
                timeout_err <= 1'b1;
                req_ready   <= 1'b1;
                st          <= ST_IDLE;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_wr_ctrl_chk.sv
module nor_wr_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        timeout_err,
  input logic [15:0] flash_addr,
  input logic [15:0] flash_dq_out,
  input logic        flash_dq_oe,
  input logic        flash_ce_n,
  input logic        flash_we_n,
  input logic        flash_oe_n
);
  // R9
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!flash_we_n && !flash_oe_n));

  // R9
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> !flash_ce_n);

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_we_n) |-> (flash_dq_oe && $stable(flash_dq_out)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);

  // R11
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout_err));

  // R11
  end_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (done || timeout_err) |-> req_ready);

  // R11
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind nor_wr_ctrl nor_wr_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .timeout_err(timeout_err), .flash_addr(flash_addr),
  .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
  .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
);

// File: tb/nor_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module nor_wr_ctrl_tb_top;
  localparam int TS = 2, TP = 3, TH = 1, TR = 2;
  localparam int TOP = 400, TOS = 600, TOC = 800;
  localparam int PB = 100, SB = 150, CB = 200;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, poll_data = 1'b0;
  logic [1:0]  req_op = '0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic        req_ready, done, timeout_err, flash_dq_oe;
  logic        flash_ce_n, flash_we_n, flash_oe_n;
  logic [15:0] rd_data, flash_addr, flash_dq_out;
  logic [15:0] dq_model = '0;

  nor_wr_ctrl #(
    .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_RECOV(TR),
    .TMR_W(16), .TO_PROG(TOP), .TO_SECT(TOS), .TO_CHIP(TOC)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_data(poll_data),
    .req_ready(req_ready), .done(done), .timeout_err(timeout_err),
    .rd_data(rd_data), .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
    .flash_dq_oe(flash_dq_oe), .flash_dq_in(dq_model),
    .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural flash model
  typedef struct { logic [15:0] a; logic [15:0] d; } wr_t;
  logic [15:0] mem [int];
  wr_t wq[$];
  wr_t eq[$];
  int  busy_cnt = 0, busy_end = 0, cyc = 0;
  bit  hang = 0;
  logic tog = 1'b0, tgt7 = 1'b0, we_d = 1'b1, oe_d = 1'b1;
  logic [15:0] last_d = '0;

  function automatic logic [15:0] rd_word(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      we_d <= 1'b1; oe_d <= 1'b1;
    end else begin
      we_d <= flash_we_n;
      oe_d <= flash_oe_n;
      if (busy_cnt > 0 && !hang) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) busy_end = cyc;
      end
      if (!we_d && flash_we_n && !flash_ce_n) begin
        wq.push_back('{flash_addr, flash_dq_out});
        if (last_d == 16'h00A0) begin
          mem[int'(flash_addr)] = flash_dq_out;
          tgt7 <= flash_dq_out[7];
          busy_cnt <= PB;
        end else if (flash_dq_out == 16'h0030 && last_d == 16'h0055) begin
          for (int i = 0; i < 2048; i++)
            mem.delete(int'({flash_addr[15:11], 11'b0}) + i);
          tgt7 <= 1'b1;
          busy_cnt <= SB;
        end else if (flash_dq_out == 16'h0010 && last_d == 16'h0055) begin
          mem.delete();
          tgt7 <= 1'b1;
          busy_cnt <= CB;
        end
        last_d = flash_dq_out;
      end
      if (!oe_d && flash_oe_n) tog <= ~tog;
      dq_model <= (busy_cnt > 0) ? {8'h00, ~tgt7, tog, 6'h00} : rd_word(flash_addr);
    end
  end

  // Per-clock strobe monitor (R9)
  int viol = 0, wlow = 0, olow = 0, chi = 0;
  bit seen = 0;
  logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
  logic [15:0] p_addr = '0, p_dq = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!flash_we_n && !flash_oe_n) viol++;
      if (!flash_we_n && flash_ce_n) viol++;
      if (!flash_oe_n && flash_ce_n) viol++;
      if (!flash_ce_n && !p_ce && flash_addr != p_addr) viol++;
      if ((!flash_we_n && p_we && p_ce) || (!flash_oe_n && p_oe && p_ce)) viol++;
      if (!flash_we_n) wlow++;
      else begin
        if (!p_we && (wlow != TP || !flash_dq_oe || flash_dq_out != p_dq)) viol++;
        wlow = 0;
      end
      if (!flash_oe_n) olow++;
      else begin
        if (!p_oe && olow != TP) viol++;
        olow = 0;
      end
      if (flash_ce_n) chi++;
      else begin
        if (p_ce && seen && chi < TR) viol++;
        chi = 0;
        seen = 1;
      end
      p_ce = flash_ce_n; p_we = flash_we_n; p_oe = flash_oe_n;
      p_addr = flash_addr; p_dq = flash_dq_out;
    end
  end

  // Expected command writes, from R3, R4 and R5
  task automatic build_exp(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d);
    eq.delete();
    if (op == 2'd0) return;
    eq.push_back('{16'h5555, 16'h00AA});
    eq.push_back('{16'h2AAA, 16'h0055});
    if (op == 2'd1) begin
      eq.push_back('{16'h5555, 16'h00A0});
      eq.push_back('{a, d});
    end else begin
      eq.push_back('{16'h5555, 16'h0080});
      eq.push_back('{16'h5555, 16'h00AA});
      eq.push_back('{16'h2AAA, 16'h0055});
      if (op == 2'd2) eq.push_back('{{a[15:11], 11'b0}, 16'h0030});
      else            eq.push_back('{16'h5555, 16'h0010});
    end
  endtask

  function automatic int seq_bad();
    if (eq.size() != wq.size()) return 100 + wq.size();
    foreach (eq[i]) if (eq[i].a !== wq[i].a || eq[i].d !== wq[i].d) return i;
    return -1;
  endfunction

  bit gd, ge;
  int s_cyc, e_cyc;

  task automatic run_op(input logic [1:0] op, input logic [15:0] a,
                        input logic [15:0] d, input logic m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wq.delete();
    req_op = op; req_addr = a; req_data = d; poll_data = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    s_cyc = cyc;
    gd = 0; ge = 0; e_cyc = 0;
    for (int i = 0; i < 5000 && !gd && !ge; i++) begin
      @(negedge clk);
      if (done) gd = 1;
      if (timeout_err) ge = 1;
      if (gd || ge) e_cyc = cyc;
    end
    @(negedge clk);
    chk(!done && !timeout_err && req_ready, "R11", "pulse width/ready",
        {done, timeout_err, req_ready}, 3'b001);
  endtask

  task automatic run_write(input logic [1:0] op, input logic [15:0] a,
                           input logic [15:0] d, input logic m, input string rq);
    int b;
    build_exp(op, a, d);
    run_op(op, a, d, m);
    b = seq_bad();
    chk(b < 0, rq, "command sequence", b, -1);
    chk(gd && !ge, rq, "done", {gd, ge}, 2'b10);
    chk(e_cyc > busy_end, m ? "R7" : "R6", "done after flash ready", e_cyc, busy_end);
  endtask

  task automatic run_read(input logic [15:0] a, input logic [15:0] exp, input string rq);
    run_op(2'd0, a, 16'h0, 1'b0);
    chk(gd && wq.size() == 0, "R2", "read done, no writes", {gd, 8'(wq.size())}, 9'h100);
    chk(rd_data == exp, rq, "read word", rd_data, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe, "R1", "strobes in reset",
        {flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !timeout_err && flash_ce_n && flash_we_n && flash_oe_n,
        "R1", "state after reset", {req_ready, done, timeout_err, flash_ce_n}, 4'b1001);

    run_write(2'd1, 16'h0810, 16'h1234, 1'b0, "R3");
    run_read(16'h0810, 16'h1234, "R2");
    run_write(2'd1, 16'h0811, 16'h80C3, 1'b1, "R7");
    run_write(2'd1, 16'h1000, 16'h4A21, 1'b1, "R7");
    run_read(16'h0811, 16'h80C3, "R7");
    run_read(16'h7FFF, 16'hFFFF, "R2");

    run_write(2'd2, 16'h0A55, 16'h0000, 1'b1, "R4");
    run_read(16'h0810, 16'hFFFF, "R4");
    run_read(16'h1000, 16'h4A21, "R4");

    run_write(2'd3, 16'h0000, 16'h0000, 1'b0, "R5");
    run_read(16'h1000, 16'hFFFF, "R5");

    // R8 timeout with a flash that never finishes
    hang = 1;
    run_op(2'd1, 16'h2222, 16'h5A5A, 1'b0);
    chk(ge && !gd, "R8", "timeout flagged", {ge, gd}, 2'b10);
    chk(e_cyc - s_cyc >= TOP, "R8", "not before limit", e_cyc - s_cyc, TOP);
    hang = 0;
    repeat (PB + 10) @(negedge clk);
    run_write(2'd1, 16'h3333, 16'h0F0F, 1'b1, "R8");
    run_read(16'h3333, 16'h0F0F, "R8");

    // R10 requests while busy are ignored
    build_exp(2'd1, 16'h4444, 16'h7777);
    while (!req_ready) @(negedge clk);
    wq.delete();
    req_op = 2'd1; req_addr = 16'h4444; req_data = 16'h7777; poll_data = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_op = 2'd3; req_addr = 16'h0000;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    gd = 0;
    for (int i = 0; i < 5000 && !gd; i++) begin
      @(negedge clk);
      if (done) gd = 1;
    end
    chk(gd && seq_bad() < 0, "R10", "only first request run", seq_bad(), -1);
    begin
      int lows = 0;
      repeat (40) begin
        @(negedge clk);
        if (!flash_ce_n) lows++;
      end
      chk(lows == 0 && wq.size() == 4, "R10", "no late bus cycle", lows, 0);
    end
    run_read(16'h4444, 16'h7777, "R10");

    chk(viol == 0, "R9", "strobe timing violations", viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule